// File: doc/BRIEF.md
# PTP Event Frame Detector

This block watches a byte-wide stream of Ethernet frames on one datapath, transmit or receive. It raises a single-cycle capture strobe when the frame carries a precision-time event message that should be timestamped. The parser follows the frame through the MAC header, an optional VLAN tag, the IPv4 header and the UDP header into the PTP common header. On the way it latches the message type, the domain (subdomain) byte, the source port identity and the sequence ID. A timestamp unit beside the datapath uses the strobe to store its counter value together with the latched identifiers.

The block qualifies a frame only when every layer matches, the message type is the one wanted for the current mode and direction, and the domain byte equals the configured value. The qualifying type swaps between Sync and Delay_Req with the master/slave setting and the path direction. Checksums are not examined, and no timestamp storage is done here.

Top module: `ptp_event_detector`

## Requirements
- R1: The MAC type field at frame bytes 12-13 must be 16'h0800. Alternatively it may be 16'h8100, in which case bytes 14-15 are the tag and bytes 16-17 must be 16'h0800. Any other type gives no strobe.
- R2: With cfg_master=1, a frame on the transmit path (cfg_rx_path=0) qualifies when the PTP messageType nibble (low 4 bits of PTP byte 0) is 0 (Sync). On the receive path (cfg_rx_path=1) it qualifies when that nibble is 1 (Delay_Req).
- R3: With cfg_master=0 the choice is reversed: type 1 qualifies on transmit and type 0 on receive.
- R4: The PTP domain byte (PTP header offset 4) must equal cfg_subdomain, or no strobe is raised.
- R5: The IPv4 version nibble must be 4, the protocol byte (IP offset 9) must be 17, and the UDP destination port (UDP offsets 2-3, big-endian) must be 319. Otherwise no strobe is raised.
- R6: The UDP header starts 4*IHL bytes after the IP header start, so IP options are skipped. An IHL below 5 rejects the frame.
- R7: cap_strobe is high for exactly one cycle, in the cycle after the byte at PTP offset 31 is accepted, and at most once per frame. While it is high, cap_seq_id holds PTP offsets 30-31 (big-endian), cap_port_id holds offsets 20-29 (first byte most significant), and cap_msg_type and cap_subdomain hold the frame's fields.
- R8: A byte taken with frame_start=1 is byte 0 of a new frame. Any partly parsed earlier frame is discarded and produces no strobe.
- R9: Cycles with byte_valid=0 are ignored. Idle gaps inside a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Marks the first byte of a frame (qualified by byte_valid) |
| byte_valid | input | 1 | byte_data carries a frame byte this cycle |
| byte_data | input | 8 | Frame byte |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_rx_path | input | 1 | 1 = stream is the receive path, 0 = transmit path |
| cfg_subdomain | input | SUBDOM_W | Domain value a frame must carry |
| cap_strobe | output | 1 | One-cycle capture pulse for a qualifying frame |
| cap_msg_type | output | 4 | Latched messageType nibble |
| cap_subdomain | output | SUBDOM_W | Latched domain byte |
| cap_seq_id | output | 16 | Latched sequence ID |
| cap_port_id | output | 8*PORT_ID_BYTES | Latched source port identity |

## Verification
The assertions assume that the three configuration inputs stay constant from the start of a frame until its strobe. They also assume that frame_start is only meaningful together with byte_valid. The bench changes mode, direction and domain only between frames, after the trailing idle cycles, and raises frame_start only on a valid byte 0. Frames are assembled byte by byte from their field values. The bench then compares the strobe position and the latched fields against what those fields say.

// File: rtl/ptp_det_pkg.sv
package ptp_det_pkg;

   typedef enum logic [2:0] {
      SEC_ETH,
      SEC_IP,
      SEC_UDP,
      SEC_PTP,
      SEC_IDLE
   } sec_e;

   // layer offsets and lengths
   localparam int MAC_HDR_LEN   = 14;
   localparam int TAG_LEN       = 4;
   localparam int IP_MIN_IHL    = 5;
   localparam int IP_PROTO_OFF  = 9;
   localparam int UDP_HDR_LEN   = 8;
   localparam int UDP_DPORT_OFF = 2;
   localparam int PTP_TYPE_OFF  = 0;
   localparam int PTP_DOM_OFF   = 4;
   localparam int PTP_PORT_OFF  = 20;
   localparam int PTP_SEQ_OFF   = 30;
   localparam int PTP_LAST_OFF  = 31;

   localparam logic [15:0] TYPE_IPV4 = 16'h0800;
   localparam logic [15:0] TYPE_TAG  = 16'h8100;
   localparam logic [7:0]  PROTO_UDP = 8'd17;
   localparam logic [3:0]  MSG_SYNC  = 4'd0;
   localparam logic [3:0]  MSG_DREQ  = 4'd1;

endpackage

// File: rtl/ptp_det_walker.sv
module ptp_det_walker
   import ptp_det_pkg::*;
#(
   parameter int          IDX_W      = 8,
   parameter bit          VLAN_EN    = 1'b1,
   parameter logic [15:0] EVENT_PORT = 16'd319
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   output logic             ptp_take,
   output logic [IDX_W-1:0] ptp_idx
);

   localparam logic [IDX_W-1:0] L_MAC   = IDX_W'(MAC_HDR_LEN);
   localparam logic [IDX_W-1:0] L_TAGGED = IDX_W'(MAC_HDR_LEN + TAG_LEN);
   localparam logic [IDX_W-1:0] L_PROTO = IDX_W'(IP_PROTO_OFF);
   localparam logic [IDX_W-1:0] L_DPORT = IDX_W'(UDP_DPORT_OFF);
   localparam logic [IDX_W-1:0] L_UDPE  = IDX_W'(UDP_HDR_LEN - 1);
   localparam logic [IDX_W-1:0] L_PTPE  = IDX_W'(PTP_LAST_OFF);

   sec_e             sec_q, cur_sec, nxt_sec;
   logic [IDX_W-1:0] idx_q, cur_idx, nxt_idx;
   logic             vlan_q, cur_vlan, nxt_vlan;
   logic [3:0]       ihl_q, nxt_ihl;
   logic [7:0]       hi_q, nxt_hi;
   logic [15:0]      word;
   logic [IDX_W-1:0] mac_len;
   logic [IDX_W-1:0] ip_end;
   logic             tag_ok;

   generate
      if (VLAN_EN) begin : g_tag
         assign tag_ok  = !cur_vlan;
         assign mac_len = cur_vlan ? L_TAGGED : L_MAC;
      end else begin : g_notag
         assign tag_ok  = 1'b0;
         assign mac_len = L_MAC;
      end
   endgenerate

   always_comb begin
      cur_sec  = frame_start ? SEC_ETH : sec_q;
      cur_idx  = frame_start ? '0 : idx_q;
      cur_vlan = frame_start ? 1'b0 : vlan_q;
      word     = {hi_q, byte_data};
      ip_end   = IDX_W'({ihl_q, 2'b00}) - IDX_W'(1);

      nxt_sec  = cur_sec;
      nxt_idx  = cur_idx + IDX_W'(1);
      nxt_vlan = cur_vlan;
      nxt_ihl  = ihl_q;
      nxt_hi   = hi_q;

      case (cur_sec)
         SEC_ETH: begin
            if (cur_idx == mac_len - IDX_W'(2)) begin
               nxt_hi = byte_data;
            end else if (cur_idx == mac_len - IDX_W'(1)) begin
               if (word == TYPE_TAG && tag_ok) begin
                  nxt_vlan = 1'b1;
               end else if (word == TYPE_IPV4) begin
                  nxt_sec = SEC_IP;
                  nxt_idx = '0;
               end else begin
                  nxt_sec = SEC_IDLE;
               end
            end
         end
         SEC_IP: begin
            if (cur_idx == '0) begin
               if (byte_data[7:4] != 4'd4 || byte_data[3:0] < 4'(IP_MIN_IHL))
                  nxt_sec = SEC_IDLE;
               else
                  nxt_ihl = byte_data[3:0];
            end else if (cur_idx == L_PROTO && byte_data != PROTO_UDP) begin
               nxt_sec = SEC_IDLE;
            end else if (cur_idx == ip_end) begin
               nxt_sec = SEC_UDP;
               nxt_idx = '0;
            end
         end
         SEC_UDP: begin
            if (cur_idx == L_DPORT) begin
               nxt_hi = byte_data;
            end else if (cur_idx == L_DPORT + IDX_W'(1)) begin
               if (word != EVENT_PORT) nxt_sec = SEC_IDLE;
            end else if (cur_idx == L_UDPE) begin
               nxt_sec = SEC_PTP;
               nxt_idx = '0;
            end
         end
         SEC_PTP: begin
            if (cur_idx == L_PTPE) nxt_sec = SEC_IDLE;
         end
         default: begin
            nxt_idx = cur_idx;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= SEC_IDLE;
         idx_q  <= '0;
         vlan_q <= 1'b0;
         ihl_q  <= '0;
         hi_q   <= '0;
      end else if (byte_valid) begin
         sec_q  <= nxt_sec;
         idx_q  <= nxt_idx;
         vlan_q <= nxt_vlan;
         ihl_q  <= nxt_ihl;
         hi_q   <= nxt_hi;
      end
   end

   assign ptp_take = byte_valid && (cur_sec == SEC_PTP);
   assign ptp_idx  = cur_idx;

endmodule

// File: rtl/ptp_det_field.sv
module ptp_det_field #(
   parameter int IDX_W  = 8,
   parameter int NBYTES = 2,
   parameter int OFFSET = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic [IDX_W-1:0]      idx,
   input  logic [7:0]            data,
   output logic [8*NBYTES-1:0]   value
);

   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (take && idx == IDX_W'(OFFSET + k))
               q <= data;
         end
         assign value[8*(NBYTES-1-k) +: 8] = q;
      end
   endgenerate

endmodule

// File: rtl/ptp_det_qual.sv
module ptp_det_qual
   import ptp_det_pkg::*;
#(
   parameter int SUBDOM_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                last_take,
   input  logic [3:0]          msg_type,
   input  logic [SUBDOM_W-1:0] dom,
   input  logic                cfg_master,
   input  logic                cfg_rx_path,
   input  logic [SUBDOM_W-1:0] cfg_subdomain,
   output logic                strobe
);

   logic [3:0] want;
   logic       hit;

   // master: Sync out, Delay_Req in; slave: the reverse
   assign want = (cfg_master == cfg_rx_path) ? MSG_DREQ : MSG_SYNC;
   assign hit  = last_take && (msg_type == want) && (dom == cfg_subdomain);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe <= 1'b0;
      else        strobe <= hit;
   end

endmodule

// File: rtl/ptp_event_detector.sv
module ptp_event_detector
   import ptp_det_pkg::*;
#(
   parameter int          IDX_W         = 8,
   parameter int          SUBDOM_W      = 8,
   parameter int          PORT_ID_BYTES = 10,
   parameter bit          VLAN_EN       = 1'b1,
   parameter logic [15:0] EVENT_PORT    = 16'd319
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_start,
   input  logic                       byte_valid,
   input  logic [7:0]                 byte_data,
   input  logic                       cfg_master,
   input  logic                       cfg_rx_path,
   input  logic [SUBDOM_W-1:0]        cfg_subdomain,
   output logic                       cap_strobe,
   output logic [3:0]                 cap_msg_type,
   output logic [SUBDOM_W-1:0]        cap_subdomain,
   output logic [15:0]                cap_seq_id,
   output logic [8*PORT_ID_BYTES-1:0] cap_port_id
);

   generate
      if (IDX_W < 6) begin : g_bad_idx
         $error("IDX_W must reach the 60-byte IP header");
      end
      if (SUBDOM_W < 1 || SUBDOM_W > 8) begin : g_bad_dom
         $error("SUBDOM_W must be 1..8");
      end
      if (PORT_ID_BYTES < 1 || PORT_ID_BYTES > PTP_SEQ_OFF - PTP_PORT_OFF) begin : g_bad_port
         $error("PORT_ID_BYTES overlaps the sequence field");
      end
   endgenerate

   logic             ptp_take;
   logic [IDX_W-1:0] ptp_idx;
   logic [7:0]       type_byte;
   logic [7:0]       dom_byte;

   ptp_det_walker #(
      .IDX_W(IDX_W), .VLAN_EN(VLAN_EN), .EVENT_PORT(EVENT_PORT)
   ) u_walker (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .byte_valid(byte_valid), .byte_data(byte_data),
      .ptp_take(ptp_take), .ptp_idx(ptp_idx)
   );

   ptp_det_field #(.IDX_W(IDX_W), .NBYTES(1), .OFFSET(PTP_TYPE_OFF)) u_type (
      .clk(clk), .rst_n(rst_n), .take(ptp_take), .idx(ptp_idx),
      .data(byte_data), .value(type_byte)
   );

   ptp_det_field #(.IDX_W(IDX_W), .NBYTES(1), .OFFSET(PTP_DOM_OFF)) u_dom (
      .clk(clk), .rst_n(rst_n), .take(ptp_take), .idx(ptp_idx),
      .data(byte_data), .value(dom_byte)
   );

   ptp_det_field #(.IDX_W(IDX_W), .NBYTES(PORT_ID_BYTES), .OFFSET(PTP_PORT_OFF)) u_port (
      .clk(clk), .rst_n(rst_n), .take(ptp_take), .idx(ptp_idx),
      .data(byte_data), .value(cap_port_id)
   );

   ptp_det_field #(.IDX_W(IDX_W), .NBYTES(2), .OFFSET(PTP_SEQ_OFF)) u_seq (
      .clk(clk), .rst_n(rst_n), .take(ptp_take), .idx(ptp_idx),
      .data(byte_data), .value(cap_seq_id)
   );

   assign cap_msg_type  = type_byte[3:0];
   assign cap_subdomain = dom_byte[SUBDOM_W-1:0];

   ptp_det_qual #(.SUBDOM_W(SUBDOM_W)) u_qual (
      .clk(clk), .rst_n(rst_n),
      .last_take(ptp_take && ptp_idx == IDX_W'(PTP_LAST_OFF)),
      .msg_type(cap_msg_type), .dom(cap_subdomain),
      .cfg_master(cfg_master), .cfg_rx_path(cfg_rx_path),
      .cfg_subdomain(cfg_subdomain),
      .strobe(cap_strobe)
   );

endmodule

// File: rtl/ptp_event_detector_chk.sv
module ptp_event_detector_chk #(
   parameter int SUBDOM_W      = 8,
   parameter int PORT_ID_BYTES = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       frame_start,
   input logic                       byte_valid,
   input logic [7:0]                 byte_data,
   input logic                       cfg_master,
   input logic                       cfg_rx_path,
   input logic [SUBDOM_W-1:0]        cfg_subdomain,
   input logic                       cap_strobe,
   input logic [3:0]                 cap_msg_type,
   input logic [SUBDOM_W-1:0]        cap_subdomain,
   input logic [15:0]                cap_seq_id,
   input logic [8*PORT_ID_BYTES-1:0] cap_port_id
);

   // R2 and R3: type carried at strobe matches mode and direction
   a_r2_r3_type_match: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> cap_msg_type == ((cfg_master == cfg_rx_path) ? 4'd1 : 4'd0));

   // R4
   a_r4_domain_match: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> cap_subdomain == cfg_subdomain);

   // R7: one-cycle pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |=> !cap_strobe);

   // R7: low sequence byte is the byte taken just before the pulse
   a_r7_seq_low: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> cap_seq_id[7:0] == $past(byte_data));

   // R9: pulse only follows an accepted byte
   a_r9_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> $past(byte_valid));

   // R8: a frame's first byte never completes a frame
   a_r8_not_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |-> !$past(frame_start && byte_valid));

endmodule

bind ptp_event_detector ptp_event_detector_chk #(
   .SUBDOM_W(SUBDOM_W), .PORT_ID_BYTES(PORT_ID_BYTES)
) u_chk (.*);

// File: tb/ptp_event_detector_bench.sv
`timescale 1ns/1ps
module ptp_event_detector_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        cfg_master = 1'b1;
   logic        cfg_rx_path = 1'b0;
   logic [7:0]  cfg_subdomain = 8'd0;
   logic        cap_strobe;
   logic [3:0]  cap_msg_type;
   logic [7:0]  cap_subdomain;
   logic [15:0] cap_seq_id;
   logic [79:0] cap_port_id;

   always #2.5 clk = ~clk;

   ptp_event_detector u_ptp_event_detector (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
      .byte_data(byte_data), .cfg_master(cfg_master), .cfg_rx_path(cfg_rx_path),
      .cfg_subdomain(cfg_subdomain), .cap_strobe(cap_strobe), .cap_msg_type(cap_msg_type),
      .cap_subdomain(cap_subdomain), .cap_seq_id(cap_seq_id), .cap_port_id(cap_port_id)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] frm [0:127];
   int flen;
   int exp_last;
   int hits;
   int hit_at;
   logic [15:0] got_seq;
   logic [79:0] got_pid;
   logic [3:0]  got_type;

   task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic build(input bit tag, input logic [15:0] etype, input int ihl,
                        input logic [7:0] proto, input logic [15:0] dport,
                        input logic [3:0] mtype, input logic [7:0] dom,
                        input logic [15:0] seq, input logic [79:0] pid);
      int p, ip, udp, ptp, iplen;
      for (int i = 0; i < 128; i++) frm[i] = 8'h00;
      for (int i = 0; i < 12; i++) frm[i] = 8'(8'h10 + i);
      p = 12;
      if (tag) begin
         frm[12] = 8'h81; frm[13] = 8'h00; frm[14] = 8'h00; frm[15] = 8'h07;
         p = 16;
      end
      frm[p] = etype[15:8]; frm[p+1] = etype[7:0];
      ip = p + 2;
      iplen = (ihl * 4 < 20) ? 20 : ihl * 4;
      frm[ip] = {4'h4, 4'(ihl)};
      frm[ip+8] = 8'd64;
      frm[ip+9] = proto;
      for (int i = 20; i < iplen; i++) frm[ip+i] = 8'h01;
      udp = ip + iplen;
      frm[udp] = 8'h01; frm[udp+1] = 8'h3F;
      frm[udp+2] = dport[15:8]; frm[udp+3] = dport[7:0];
      frm[udp+5] = 8'd44;
      ptp = udp + 8;
      frm[ptp] = {4'h0, mtype};
      frm[ptp+1] = 8'h02;
      frm[ptp+3] = 8'd44;
      frm[ptp+4] = dom;
      for (int i = 0; i < 10; i++) frm[ptp+20+i] = pid[8*(9-i) +: 8];
      frm[ptp+30] = seq[15:8];
      frm[ptp+31] = seq[7:0];
      frm[ptp+32] = 8'h7E;
      exp_last = ptp + 31;
      flen = ptp + 44;
   endtask

   task automatic sample(input int i);
      if (cap_strobe) begin
         hits++;
         hit_at   = i;
         got_seq  = cap_seq_id;
         got_pid  = cap_port_id;
         got_type = cap_msg_type;
      end
   endtask

   task automatic send(input int nbytes, input int gap);
      hits = 0;
      hit_at = -1;
      for (int i = 0; i < nbytes; i++) begin
         @(negedge clk);
         byte_data = frm[i]; byte_valid = 1'b1; frame_start = (i == 0);
         @(posedge clk); #1; sample(i);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            byte_valid = 1'b0; frame_start = 1'b0; byte_data = 8'hEE;
            @(posedge clk); #1; sample(i);
         end
      end
      @(negedge clk);
      byte_valid = 1'b0; frame_start = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #1; sample(nbytes);
      end
   endtask

   task automatic set_cfg(input bit m, input bit rx, input logic [7:0] d);
      @(negedge clk);
      cfg_master = m; cfg_rx_path = rx; cfg_subdomain = d;
   endtask

   task automatic expect_hit(input string req, input logic [15:0] seq,
                             input logic [79:0] pid, input logic [3:0] mt);
      chk({req, " strobe count"}, 80'(hits), 80'd1);
      chk({req, " strobe position"}, 80'(hit_at), 80'(exp_last));
      chk({req, " seq id"}, 80'(got_seq), 80'(seq));
      chk({req, " port id"}, got_pid, pid);
      chk({req, " msg type"}, 80'(got_type), 80'(mt));
   endtask

   task automatic expect_miss(input string req);
      chk({req, " no strobe"}, 80'(hits), 80'd0);
   endtask

   localparam logic [79:0] PID_A = 80'h0011_2233_4455_6677_8899;
   localparam logic [79:0] PID_B = 80'hA1B2_C3D4_E5F6_0718_293A;

   task automatic t_reset;
      chk("R7 reset strobe", 80'(cap_strobe), 80'd0);
      chk("R7 reset seq", 80'(cap_seq_id), 80'd0);
      chk("R7 reset port", cap_port_id, 80'd0);
   endtask

   task automatic t_master;
      set_cfg(1, 0, 8'd3);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd3, 16'h1234, PID_A);
      send(flen, 0); expect_hit("R2 master tx sync", 16'h1234, PID_A, 4'd0);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd1, 8'd3, 16'h1235, PID_A);
      send(flen, 0); expect_miss("R2 master tx delay_req");
      set_cfg(1, 1, 8'd3);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd1, 8'd3, 16'h0F0E, PID_B);
      send(flen, 0); expect_hit("R2 master rx delay_req", 16'h0F0E, PID_B, 4'd1);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd3, 16'h0F0F, PID_B);
      send(flen, 0); expect_miss("R2 master rx sync");
   endtask

   task automatic t_slave;
      set_cfg(0, 0, 8'd3);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd1, 8'd3, 16'h5501, PID_A);
      send(flen, 0); expect_hit("R3 slave tx delay_req", 16'h5501, PID_A, 4'd1);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd3, 16'h5502, PID_A);
      send(flen, 0); expect_miss("R3 slave tx sync");
      set_cfg(0, 1, 8'd3);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd3, 16'h5503, PID_B);
      send(flen, 0); expect_hit("R3 slave rx sync", 16'h5503, PID_B, 4'd0);
   endtask

   task automatic t_tag;
      set_cfg(1, 0, 8'd9);
      build(1, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd9, 16'hBEEF, PID_B);
      send(flen, 0); expect_hit("R1 tagged frame", 16'hBEEF, PID_B, 4'd0);
      build(0, 16'h86DD, 5, 8'd17, 16'd319, 4'd0, 8'd9, 16'hBEF0, PID_B);
      send(flen, 0); expect_miss("R1 other mac type");
   endtask

   task automatic t_domain;
      set_cfg(1, 0, 8'd9);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd8, 16'h0101, PID_A);
      send(flen, 0); expect_miss("R4 wrong domain");
   endtask

   task automatic t_layers;
      set_cfg(1, 0, 8'd0);
      build(0, 16'h0800, 5, 8'd6, 16'd319, 4'd0, 8'd0, 16'h0202, PID_A);
      send(flen, 0); expect_miss("R5 protocol not udp");
      build(0, 16'h0800, 5, 8'd17, 16'd320, 4'd0, 8'd0, 16'h0203, PID_A);
      send(flen, 0); expect_miss("R5 general port");
   endtask

   task automatic t_options;
      set_cfg(1, 0, 8'd0);
      build(0, 16'h0800, 7, 8'd17, 16'd319, 4'd0, 8'd0, 16'h7777, PID_B);
      send(flen, 0); expect_hit("R6 ip options", 16'h7777, PID_B, 4'd0);
      build(0, 16'h0800, 4, 8'd17, 16'd319, 4'd0, 8'd0, 16'h7778, PID_B);
      send(flen, 0); expect_miss("R6 short ihl");
   endtask

   task automatic t_restart;
      set_cfg(1, 0, 8'd0);
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd0, 16'hAA11, PID_A);
      send(exp_last, 0); expect_miss("R8 truncated frame");
      build(0, 16'h0800, 5, 8'd17, 16'd319, 4'd0, 8'd0, 16'h3322, PID_B);
      send(flen, 0); expect_hit("R8 frame after restart", 16'h3322, PID_B, 4'd0);
   endtask

   task automatic t_gaps;
      set_cfg(0, 1, 8'd5);
      build(1, 16'h0800, 6, 8'd17, 16'd319, 4'd0, 8'd5, 16'hC0DE, PID_A);
      send(flen, 2); expect_hit("R9 idle gaps", 16'hC0DE, PID_A, 4'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1; t_reset;
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_master;
      t_slave;
      t_tag;
      t_domain;
      t_layers;
      t_options;
      t_restart;
      t_gaps;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule